// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the timing and control core of a 16-bit accumulator machine with 12-bit word addresses. A 4-bit step counter is decoded into sixteen one-hot timing lines, T0 to T15. Those lines, together with an interrupt-pending flag, drive the instruction fetch, the opcode decode, the optional indirect address lookup and a three-step hardware interrupt call. The block owns the program counter, the address register, the instruction register, a temporary register for the interrupt save, the indirect-mode bit, the interrupt-pending flag and the interrupt-enable flag.

Execute units sit beside the block. They watch the one-hot opcode lines, the indirect bit and the timing lines. They end an instruction by pulsing a step-counter clear, turn interrupts on or off through two pulse inputs, and freeze the machine through a halt input. Memory is one port: word reads are combinational from the address register, so the word is valid in the same timing step, and the single write path is synchronous. The memory path carries no valid/ready handshake, because a step always completes in one clock and the step counter is the only pacing. There is no back-pressure; the only stall is the halt freeze, which lasts until reset.

The interrupt call stores the return address in word 0 and resumes execution at word 1.

Top module: `icc_sequencer`

## Requirements
- R1: Reset clears the step counter (t_o = 1, i.e. T0 active), the PC, the AR, the interrupt-pending flag r_o and the enable flag ien_o.
- R2: While not halted, exactly one bit of t_o is set (bit k means Tk), and it moves up by one position every clock. After T15 it wraps to T0, unless a clear is requested.
- R3: When sc_clr_i is high on a clock edge (and halt_i is low), the next step is T0.
- R4: With r_o = 0, at T0 the AR takes the PC. At T1 the IR takes the memory word at the AR, and the PC increments by one.
- R5: With r_o = 0, at T2 the AR takes IR bits 11:0 and i_o takes IR bit 15. d_o is one-hot, with bit k set when IR bits 14:12 equal k.
- R6: At T3, if d_o bit 7 is 0 and i_o is 1, the AR is reloaded with bits 11:0 of the memory word at the AR. Otherwise the AR is unchanged at T3.
- R7: r_o becomes 1 after any active step other than T0, T1 or T2 in which ien_o is 1 and fgi_i or fgo_i is 1. It never becomes 1 while ien_o is 0 or during T0 to T2.
- R8: With r_o = 1: at T0 the AR is cleared and the PC is saved. At T1 the saved PC is written to word 0 (mem_we_o high, address 0) and the PC is cleared. At T2 the PC increments to 1, r_o and ien_o clear, and the next step is T0.
- R9: A high halt_i on a clock edge freezes the machine until reset. t_o becomes all-zero, and the PC, AR and ien_o keep their values whatever the other inputs do.
- R10: ien_set_i sets ien_o on the next edge and ien_clr_i clears it. The interrupt completion clear of R8 takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Freeze request from an execute unit |
| sc_clr_i | input | 1 | End-of-instruction step-counter clear |
| fgi_i | input | 1 | Input device ready flag |
| fgo_i | input | 1 | Output device ready flag |
| ien_set_i | input | 1 | Interrupt enable pulse |
| ien_clr_i | input | 1 | Interrupt disable pulse |
| mem_rdata_i | input | 16 | Memory word at mem_addr_o (combinational) |
| mem_addr_o | output | 12 | Memory address (the AR) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data (saved PC) |
| t_o | output | 16 | One-hot timing step, bit k = Tk |
| d_o | output | 8 | One-hot opcode, bit k = Dk |
| i_o | output | 1 | Indirect-mode bit |
| ir_o | output | 16 | Instruction register |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| r_o | output | 1 | Interrupt cycle pending |
| ien_o | output | 1 | Interrupt enable |

## Verification
On every clock the assertions check the step rotation and its clear, the fetch and decode register transfers, the set condition of the interrupt-pending flag, the single write strobe and the interrupt exit, and the freeze after halt. Some results depend on memory contents and on the order of stimulus, so only the bench scenarios can show them. These are that the IR and the indirect pointer carry the right memory words, that word 0 really holds the return address, that execution resumes at word 1, and that pulsing the enable inputs in sequence leaves the expected value.

// File: rtl/icc_pkg.sv
package icc_pkg;
  // One flag per register-transfer step the sequencer can perform
  typedef struct packed {
    logic fetch_addr;  // AR <= PC
    logic fetch_ir;    // IR <= M[AR], PC++
    logic decode;      // AR <= IR address, I <= IR msb
    logic indirect;    // AR <= M[AR]
    logic irq_save;    // AR <= 0, TR <= PC
    logic irq_write;   // M[AR] <= TR, PC <= 0
    logic irq_done;    // PC++, IEN/R/SC cleared
  } icc_ctl_t;
endpackage

// File: rtl/icc_onehot_dec.sv
module icc_onehot_dec #(
  parameter int IN_W = 3
) (
  input  logic [IN_W-1:0]        sel_i,
  input  logic                   en_i,
  output logic [(1<<IN_W)-1:0]   hot_o
);
  localparam int OutN = 1 << IN_W;

  for (genvar k = 0; k < OutN; k++) begin : g_line
    assign hot_o[k] = en_i && (sel_i == IN_W'(k));
  end
endmodule

// File: rtl/icc_step_counter.sv
module icc_step_counter #(
  parameter int SC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  halt_i,
  input  logic                  clr_i,
  output logic [(1<<SC_W)-1:0]  t_o
);
  logic [SC_W-1:0] sc_q;
  logic            halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      if (halt_i) halted_q <= 1'b1;
      if (!(halted_q || halt_i)) begin
        if (clr_i) sc_q <= '0;
        else       sc_q <= sc_q + 1'b1;
      end
    end
  end

  // Timing lines are gated off entirely once frozen
  icc_onehot_dec #(.IN_W(SC_W)) u_tdec (
    .sel_i (sc_q),
    .en_i  (!halted_q),
    .hot_o (t_o)
  );
endmodule

// File: rtl/icc_step_ctl.sv
module icc_step_ctl
  import icc_pkg::*;
(
  input  logic [3:0] t_i,
  input  logic       r_i,
  input  logic       d7_i,
  input  logic       ind_i,
  output icc_ctl_t   ctl_o
);
  always_comb begin
    ctl_o            = '0;
    ctl_o.fetch_addr = !r_i && t_i[0];
    ctl_o.fetch_ir   = !r_i && t_i[1];
    ctl_o.decode     = !r_i && t_i[2];
    ctl_o.indirect   = !d7_i && ind_i && t_i[3];
    ctl_o.irq_save   = r_i && t_i[0];
    ctl_o.irq_write  = r_i && t_i[1];
    ctl_o.irq_done   = r_i && t_i[2];
  end
endmodule

// File: rtl/icc_intr_ctrl.sv
module icc_intr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic early_i,
  input  logic fgi_i,
  input  logic fgo_i,
  input  logic ien_set_i,
  input  logic ien_clr_i,
  input  logic irq_done_i,
  output logic r_o,
  output logic ien_o
);
  logic r_q, ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q   <= 1'b0;
      ien_q <= 1'b0;
    end else if (active_i) begin
      if (irq_done_i)
        r_q <= 1'b0;
      else if (!early_i && ien_q && (fgi_i || fgo_i))
        r_q <= 1'b1;

      if (irq_done_i)     ien_q <= 1'b0;
      else if (ien_clr_i) ien_q <= 1'b0;
      else if (ien_set_i) ien_q <= 1'b1;
    end
  end

  assign r_o   = r_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/icc_sequencer.sv
module icc_sequencer
  import icc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  parameter int SC_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         halt_i,
  input  logic                         sc_clr_i,
  input  logic                         fgi_i,
  input  logic                         fgo_i,
  input  logic                         ien_set_i,
  input  logic                         ien_clr_i,
  input  logic [ADDR_W+OPC_W:0]        mem_rdata_i,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic                         mem_we_o,
  output logic [ADDR_W+OPC_W:0]        mem_wdata_o,
  output logic [(1<<SC_W)-1:0]         t_o,
  output logic [(1<<OPC_W)-1:0]        d_o,
  output logic                         i_o,
  output logic [ADDR_W+OPC_W:0]        ir_o,
  output logic [ADDR_W-1:0]            pc_o,
  output logic [ADDR_W-1:0]            ar_o,
  output logic                         r_o,
  output logic                         ien_o
);
  localparam int DataW  = ADDR_W + OPC_W + 1;
  localparam int OpcLsb = ADDR_W;
  localparam int IndBit = DataW - 1;
  localparam int OpcTop = (1 << OPC_W) - 1;

  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [DataW-1:0]  ir_q, tr_q;
  logic              ind_q;
  logic [(1<<SC_W)-1:0] t_w;
  logic [(1<<OPC_W)-1:0] d_w;
  logic              r_w, ien_w;
  icc_ctl_t          ctl;

  icc_step_counter #(.SC_W(SC_W)) u_sc (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_i (halt_i),
    .clr_i  (sc_clr_i || ctl.irq_done),
    .t_o    (t_w)
  );

  icc_onehot_dec #(.IN_W(OPC_W)) u_opdec (
    .sel_i (ir_q[OpcLsb +: OPC_W]),
    .en_i  (1'b1),
    .hot_o (d_w)
  );

  icc_step_ctl u_ctl (
    .t_i   (t_w[3:0]),
    .r_i   (r_w),
    .d7_i  (d_w[OpcTop]),
    .ind_i (ind_q),
    .ctl_o (ctl)
  );

  icc_intr_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (|t_w),
    .early_i    (|t_w[2:0]),
    .fgi_i      (fgi_i),
    .fgo_i      (fgo_i),
    .ien_set_i  (ien_set_i),
    .ien_clr_i  (ien_clr_i),
    .irq_done_i (ctl.irq_done),
    .r_o        (r_w),
    .ien_o      (ien_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      tr_q  <= '0;
      ind_q <= 1'b0;
    end else begin
      if (ctl.fetch_addr) ar_q <= pc_q;
      if (ctl.decode)     ar_q <= ir_q[ADDR_W-1:0];
      if (ctl.indirect)   ar_q <= mem_rdata_i[ADDR_W-1:0];
      if (ctl.irq_save)   ar_q <= '0;

      if (ctl.fetch_ir || ctl.irq_done) pc_q <= pc_q + 1'b1;
      if (ctl.irq_write)                pc_q <= '0;

      if (ctl.fetch_ir) ir_q  <= mem_rdata_i;
      if (ctl.decode)   ind_q <= ir_q[IndBit];
      if (ctl.irq_save) tr_q  <= DataW'(pc_q);
    end
  end

  assign mem_addr_o  = ar_q;
  assign mem_we_o    = ctl.irq_write;
  assign mem_wdata_o = tr_q;
  assign t_o         = t_w;
  assign d_o         = d_w;
  assign i_o         = ind_q;
  assign ir_o        = ir_q;
  assign pc_o        = pc_q;
  assign ar_o        = ar_q;
  assign r_o         = r_w;
  assign ien_o       = ien_w;
endmodule

// File: rtl/icc_sequencer_chk.sv
module icc_sequencer_chk #(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  parameter int SC_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  halt_i,
  input logic                  sc_clr_i,
  input logic                  fgi_i,
  input logic                  fgo_i,
  input logic                  ien_set_i,
  input logic                  ien_clr_i,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic                  mem_we_o,
  input logic [(1<<SC_W)-1:0]  t_o,
  input logic                  i_o,
  input logic [ADDR_W+OPC_W:0] ir_o,
  input logic [ADDR_W-1:0]     pc_o,
  input logic [ADDR_W-1:0]     ar_o,
  input logic                  r_o,
  input logic                  ien_o
);
  localparam int NT = 1 << SC_W;
  localparam int DataW = ADDR_W + OPC_W + 1;

  p_onehot_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_o));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_o != '0 && !sc_clr_i && !halt_i && !(r_o && t_o[2]))
    |=> t_o == $past({t_o[NT-2:0], t_o[NT-1]}));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_o != '0 && sc_clr_i && !halt_i) |=> t_o[0]);

  p_fetch_ar_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_o && t_o[0]) |=> ar_o == $past(pc_o));

  p_fetch_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_o && t_o[1]) |=> pc_o == $past(pc_o) + 1'b1);

  p_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_o && t_o[2]) |=> (ar_o == $past(ir_o[ADDR_W-1:0])) && (i_o == $past(ir_o[DataW-1])));

  p_rset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_o != '0 && t_o[2:0] == 3'b000 && ien_o && (fgi_i || fgo_i)) |=> r_o);

  p_rquiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_o && !ien_o) |=> !r_o);

  p_we_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (r_o && t_o[1] && mem_addr_o == '0));

  p_irq_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_o && t_o[2] && !halt_i)
    |=> (!r_o && !ien_o && t_o[0] && pc_o == $past(pc_o) + 1'b1));

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (t_o == '0) |=> (t_o == '0 && $stable(pc_o) && $stable(ar_o) && $stable(ien_o)));

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> t_o == '0);

  p_ien_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (t_o != '0 && ien_set_i && !ien_clr_i && !(r_o && t_o[2])) |=> ien_o);
endmodule

bind icc_sequencer icc_sequencer_chk #(
  .ADDR_W(ADDR_W), .OPC_W(OPC_W), .SC_W(SC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .sc_clr_i(sc_clr_i),
  .fgi_i(fgi_i), .fgo_i(fgo_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
  .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .t_o(t_o), .i_o(i_o),
  .ir_o(ir_o), .pc_o(pc_o), .ar_o(ar_o), .r_o(r_o), .ien_o(ien_o)
);

// File: tb/icc_sequencer_tb_top.sv
`timescale 1ns/1ps
module icc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        halt_i, sc_clr_i, fgi_i, fgo_i, ien_set_i, ien_clr_i;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] t_o;
  logic [7:0]  d_o;
  logic        i_o;
  logic [15:0] ir_o;
  logic [11:0] pc_o, ar_o;
  logic        r_o, ien_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [11:0] exp_pc;
  logic [15:0] mem [0:4095];

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  icc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .sc_clr_i(sc_clr_i),
    .fgi_i(fgi_i), .fgo_i(fgo_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .t_o(t_o), .d_o(d_o), .i_o(i_o), .ir_o(ir_o),
    .pc_o(pc_o), .ar_o(ar_o), .r_o(r_o), .ien_o(ien_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] step_hot(input int k);
    return 16'h1 << k;
  endfunction

  function automatic logic [11:0] exp_after_t3(input logic [15:0] w, input logic [15:0] ptr);
    return (w[14:12] != 3'd7 && w[15]) ? ptr[11:0] : w[11:0];
  endfunction

  // Entered at a negedge in T0 with r_o = 0.
  // mode: 0 normal, 1 wrap past T15, 2 enable-pulse test, 3 raise interrupt
  task automatic run_instr(input logic [15:0] w, input int extra, input int mode);
    logic [15:0] ptr;
    mem[w[11:0]] = 16'($urandom);
    mem[exp_pc]  = w;
    ptr = mem[w[11:0]];
    if (mode == 3) fgi_i = 1'b1;
    tick();
    chk("R4 AR<=PC at T0", 32'(ar_o), 32'(exp_pc));
    chk("R2 step T1", 32'(t_o), 32'(step_hot(1)));
    tick();
    chk("R4 IR<=M[AR]", 32'(ir_o), 32'(w));
    chk("R4 PC increment", 32'(pc_o), 32'(exp_pc + 12'd1));
    tick();
    chk("R5 AR<=IR addr", 32'(ar_o), 32'(w[11:0]));
    chk("R5 indirect bit", 32'(i_o), 32'(w[15]));
    chk("R5 opcode one-hot", 32'(d_o), 32'(8'h1 << w[14:12]));
    if (mode == 3) chk("R7 no set in T0..T2", 32'(r_o), 32'd0);
    tick();
    chk("R6 AR after T3", 32'(ar_o), 32'(exp_after_t3(w, ptr)));
    exp_pc = exp_pc + 12'd1;
    if (mode == 3) chk("R7 set after T3", 32'(r_o), 32'd1);
    if (mode == 0) begin
      fgi_i = 1'($urandom);
      fgo_i = 1'($urandom);
    end
    if (mode == 1) begin
      while (!t_o[15]) tick();
      tick();
      chk("R2 wrap to T0", 32'(t_o), 32'(step_hot(0)));
      return;
    end
    if (mode == 2) begin
      ien_set_i = 1'b1; tick(); ien_set_i = 1'b0;
      chk("R10 enable set", 32'(ien_o), 32'd1);
      ien_clr_i = 1'b1; tick(); ien_clr_i = 1'b0;
      chk("R10 enable clear", 32'(ien_o), 32'd0);
      ien_set_i = 1'b1; tick(); ien_set_i = 1'b0;
      chk("R10 enable set again", 32'(ien_o), 32'd1);
    end else begin
      repeat (extra) tick();
    end
    if (mode == 0) chk("R7 no set while disabled", 32'(r_o), 32'd0);
    fgo_i = 1'b0;
    if (mode != 3) fgi_i = 1'b0;
    sc_clr_i = 1'b1;
    tick();
    sc_clr_i = 1'b0;
    chk("R3 clear to T0", 32'(t_o), 32'(step_hot(0)));
  endtask

  task automatic run_irq();
    logic [11:0] saved = exp_pc;
    tick();
    chk("R8 AR cleared", 32'(ar_o), 32'd0);
    chk("R8 write strobe", 32'(mem_we), 32'd1);
    chk("R8 write data", 32'(mem_wdata), 32'(saved));
    fgi_i = 1'b0;
    tick();
    chk("R8 word 0 holds return", 32'(mem[0]), 32'(saved));
    chk("R8 PC cleared", 32'(pc_o), 32'd0);
    tick();
    chk("R8 PC is 1", 32'(pc_o), 32'd1);
    chk("R8 flags cleared", 32'({r_o, ien_o}), 32'd0);
    chk("R8 back to T0", 32'(t_o), 32'(step_hot(0)));
    exp_pc = 12'd1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [11:0] hold_pc, hold_ar;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0;
    rst_n = 1'b0; halt_i = 0; sc_clr_i = 0; fgi_i = 0; fgo_i = 0;
    ien_set_i = 0; ien_clr_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset step", 32'(t_o), 32'(step_hot(0)));
    chk("R1 reset PC/AR", 32'({pc_o, ar_o}), 32'd0);
    chk("R1 reset flags", 32'({r_o, ien_o}), 32'd0);
    exp_pc = 12'd0;

    // directed: indirect taken, indirect with opcode 7, direct
    run_instr(16'h9123, 2, 0);
    run_instr(16'hF456, 0, 0);
    run_instr(16'h2789, 10, 0);
    for (int n = 0; n < 40; n++) begin
      run_instr(16'($urandom), int'($urandom % 8), (n % 10 == 9) ? 1 : 0);
    end
    run_instr(16'hA0F0, 0, 2);
    run_instr(16'h1234, 1, 3);
    run_irq();
    for (int n = 0; n < 5; n++) run_instr(16'($urandom), 1, 0);

    // halt freeze
    tick();
    halt_i = 1'b1;
    tick();
    halt_i = 1'b0;
    chk("R9 timing off", 32'(t_o), 32'd0);
    hold_pc = pc_o;
    hold_ar = ar_o;
    for (int n = 0; n < 4; n++) begin
      sc_clr_i = 1'($urandom); fgi_i = 1'b1; ien_set_i = 1'b1;
      tick();
    end
    sc_clr_i = 0; fgi_i = 0; ien_set_i = 0;
    chk("R9 still frozen", 32'(t_o), 32'd0);
    chk("R9 PC held", 32'(pc_o), 32'(hold_pc));
    chk("R9 AR held", 32'(ar_o), 32'(hold_ar));
    chk("R9 IEN held", 32'(ien_o), 32'd0);

    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    chk("R1 reset after halt", 32'(t_o), 32'(step_hot(0)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule